// File: doc/BRIEF.md
# Multidrop Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial transceiver. Its transmit and receive paths run at the same time and do not depend on each other. Both paths share one baud tick, which runs at sixteen times the bit rate. The character format can be changed at run time: 5 to 8 data bits, one or two stop bits, and no parity, even parity or odd parity. An address mode supports multidrop buses. In this mode a ninth bit follows eight data bits and marks address characters. The receiver discards data characters until it has seen an address character equal to its own station address.

Each path has a one-character holding register in front of its shift register. The host can queue one character while the previous character is still on the line. The receiver keeps one finished character while the next one arrives. The host writes with a strobe while `tx_ready` is high. It reads with a strobe while `rx_valid` is high. Framing, parity and overrun errors are reported on dedicated outputs.

Top module: `mdrop_uart`

## Requirements
- R1: After reset, `txd` is 1, `tx_ready` is 1, and `rx_valid`, `err_frame`, `err_parity` and `err_overrun` are 0.
- R2: A transmitted character is a 0 start bit, then the data bits LSB first, then the optional parity or ninth bit, then the stop bits at 1. `char_len` selects 5, 6, 7 or 8 data bits for codes 0 to 3.
- R3: `parity_mode` code 0 means no parity bit, code 1 means even parity and code 2 means odd parity, computed over the data bits. The receiver sets `err_parity` with the character if the received parity does not match.
- R4: `two_stop` = 1 sends two stop bits. The receiver sets `err_frame` with the character if any of its stop bits samples 0.
- R5: A write is taken only while `tx_ready` is 1, and `tx_ready` is 0 in the cycle after the write. Once the holding register has passed its character to a busy shifter and holds a second one, `tx_ready` stays 0 and any further write is ignored.
- R6: A received character appears on `rx_data` with `rx_valid` = 1 and stays stable until `rx_rd` is pulsed. The pulse clears `rx_valid`.
- R7: If a character completes while `rx_valid` = 1 and no read is pending, `err_overrun` is set and the held character is kept. A read clears `err_overrun`.
- R8: A low pulse on `rxd` that has ended by the middle of the start bit is ignored, and no character results.
- R9: When `addr_mode` = 1, the format is 8 data bits plus a ninth bit in the parity slot, and `parity_mode` is ignored. `tx_data[8]` is sent as the ninth bit, and `rx_data[8]` returns it.
- R10: In address mode, an address character (ninth bit 1) that equals `own_addr` is delivered and makes the receiver addressed. A non-matching address character is dropped and makes it unaddressed. Data characters are delivered only while the receiver is addressed.
- R11: One bit lasts 16 × (`divisor` + 1) clock cycles on both paths.
- R12: A character can be transmitted and another received in the same time window, with no effect of one on the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| divisor | input | DIV_W | Oversample tick period minus one |
| char_len | input | 2 | Data bits: 0..3 selects 5..8 |
| two_stop | input | 1 | 1 selects two stop bits |
| parity_mode | input | 2 | 0 none, 1 even, 2 odd |
| addr_mode | input | 1 | Enables 9-bit multidrop format |
| own_addr | input | 8 | Station address for address matching |
| tx_wr | input | 1 | Write strobe for `tx_data` |
| tx_data | input | 9 | Character to send; bit 8 is the ninth bit |
| tx_ready | output | 1 | Transmit holding register empty |
| txd | output | 1 | Serial output, idles high |
| rxd | input | 1 | Serial input |
| rx_rd | input | 1 | Read strobe, consumes the held character |
| rx_data | output | 9 | Received character; bit 8 is the ninth bit |
| rx_valid | output | 1 | Receive holding register full |
| err_frame | output | 1 | Stop-bit error on the held character |
| err_parity | output | 1 | Parity error on the held character |
| err_overrun | output | 1 | A character was lost while the holding register was full |

## Verification
The addressed state is the hardest part to reach. It is not visible at any port. It shows only through which later characters get delivered. The stimulus therefore runs a fixed sequence in address mode:
1. A data character while unaddressed.
2. A matching address character.
3. A data character while addressed.
4. A non-matching address character.
5. A final data character.

Each step is checked for delivery or silence. The one-stop framing error is also hard to provoke cleanly. Its low stop bit leaves the line low past the sampling point, so the receiver sees a false start. That false start must then be rejected as a glitch before the next row begins.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  localparam logic [3:0] OVS_LAST = 4'd15;
  localparam logic [3:0] OVS_MID  = 4'd7;
  localparam int         FRAME_W  = 12;

  typedef enum logic [1:0] {PAR_NONE = 2'd0, PAR_EVEN = 2'd1, PAR_ODD = 2'd2} par_e;
  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_SLOT, RX_STOP} rx_st_e;

  function automatic logic [3:0] data_bits(input logic [1:0] sel, input logic adr);
    return adr ? 4'd8 : (4'd5 + {2'b00, sel});
  endfunction

  function automatic logic [7:0] data_mask(input logic [3:0] n);
    return 8'hFF >> (4'd8 - n);
  endfunction
endpackage

// File: rtl/mdu_tick.sv
module mdu_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == '0) begin
      cnt  <= divisor;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt - 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/mdu_tx.sv
module mdu_tx
  import mdu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       wr,
  input  logic [8:0] wdata,
  input  logic [1:0] char_len,
  input  logic       two_stop,
  input  logic [1:0] parity_mode,
  input  logic       addr_mode,
  output logic       ready,
  output logic       txd
);
  logic               hold_v;
  logic [8:0]         hold_d;
  logic               busy;
  logic [FRAME_W-1:0] sr;
  logic [3:0]         left;
  logic [3:0]         tcnt;

  logic [FRAME_W-1:0] frame;
  logic [3:0]         n_bits;
  logic [3:0]         pos;
  logic [3:0]         len;
  logic               par_bit;

  always_comb begin
    n_bits  = data_bits(char_len, addr_mode);
    par_bit = (^(hold_d[7:0] & data_mask(n_bits))) ^ (parity_mode == PAR_ODD);
    frame   = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (4'(i) < n_bits) frame[i+1] = hold_d[i];
    end
    pos = n_bits + 4'd1;
    if (addr_mode) begin
      frame[pos] = hold_d[8];
      pos = pos + 4'd1;
    end else if (parity_mode != PAR_NONE) begin
      frame[pos] = par_bit;
      pos = pos + 4'd1;
    end
    len = pos + (two_stop ? 4'd2 : 4'd1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_v <= 1'b0;
      hold_d <= '0;
      busy   <= 1'b0;
      txd    <= 1'b1;
      sr     <= '1;
      left   <= '0;
      tcnt   <= '0;
    end else begin
      if (wr && !hold_v) begin
        hold_v <= 1'b1;
        hold_d <= wdata;
      end
      if (!busy && hold_v) begin
        busy   <= 1'b1;
        hold_v <= 1'b0;
        txd    <= 1'b0;
        sr     <= frame >> 1;
        left   <= len - 4'd1;
        tcnt   <= '0;
      end else if (busy && tick) begin
        if (tcnt == OVS_LAST) begin
          tcnt <= '0;
          if (left == '0) begin
            busy <= 1'b0;
            txd  <= 1'b1;
          end else begin
            txd  <= sr[0];
            sr   <= {1'b1, sr[FRAME_W-1:1]};
            left <= left - 4'd1;
          end
        end else begin
          tcnt <= tcnt + 4'd1;
        end
      end
    end
  end

  assign ready = !hold_v;
endmodule

// File: rtl/mdu_rx.sv
module mdu_rx
  import mdu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       rxd,
  input  logic [1:0] char_len,
  input  logic       two_stop,
  input  logic [1:0] parity_mode,
  input  logic       addr_mode,
  input  logic [7:0] own_addr,
  input  logic       rd,
  output logic [8:0] rx_data,
  output logic       rx_valid,
  output logic       err_frame,
  output logic       err_parity,
  output logic       err_overrun
);
  logic       s1, s2;
  rx_st_e     st;
  logic [3:0] tcnt;
  logic [2:0] bidx;
  logic [7:0] sh;
  logic       pbit;
  logic       ferr;
  logic       stops_left;
  logic       addressed;

  logic [3:0] n_bits;
  logic [7:0] data_m;
  logic       has_slot;
  logic       fin;
  logic       par_bad;
  logic       ninth;
  logic       want;

  always_comb begin
    n_bits   = data_bits(char_len, addr_mode);
    data_m   = sh & data_mask(n_bits);
    has_slot = addr_mode || (parity_mode != PAR_NONE);
    fin      = (st == RX_STOP) && tick && (tcnt == OVS_LAST) && !stops_left;
    par_bad  = !addr_mode && (parity_mode != PAR_NONE) &&
               ((^data_m ^ pbit) != (parity_mode == PAR_ODD));
    ninth    = addr_mode && pbit;
    want     = !addr_mode || (ninth ? (data_m == own_addr) : addressed);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= rxd;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= RX_IDLE;
      tcnt       <= '0;
      bidx       <= '0;
      sh         <= '0;
      pbit       <= 1'b0;
      ferr       <= 1'b0;
      stops_left <= 1'b0;
    end else if (tick) begin
      case (st)
        RX_IDLE: if (!s2) begin
          st   <= RX_START;
          tcnt <= '0;
        end
        RX_START: if (tcnt == OVS_MID) begin
          tcnt <= '0;
          bidx <= '0;
          sh   <= '0;
          pbit <= 1'b0;
          st   <= s2 ? RX_IDLE : RX_DATA;
        end else tcnt <= tcnt + 4'd1;
        RX_DATA: if (tcnt == OVS_LAST) begin
          tcnt     <= '0;
          sh[bidx] <= s2;
          if (bidx == 3'(n_bits - 4'd1)) begin
            st         <= has_slot ? RX_SLOT : RX_STOP;
            ferr       <= 1'b0;
            stops_left <= two_stop;
          end else bidx <= bidx + 3'd1;
        end else tcnt <= tcnt + 4'd1;
        RX_SLOT: if (tcnt == OVS_LAST) begin
          tcnt <= '0;
          pbit <= s2;
          st   <= RX_STOP;
        end else tcnt <= tcnt + 4'd1;
        RX_STOP: if (tcnt == OVS_LAST) begin
          tcnt <= '0;
          if (!s2) ferr <= 1'b1;
          if (stops_left) stops_left <= 1'b0;
          else st <= RX_IDLE;
        end else tcnt <= tcnt + 4'd1;
        default: st <= RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addressed   <= 1'b0;
      rx_data     <= '0;
      rx_valid    <= 1'b0;
      err_frame   <= 1'b0;
      err_parity  <= 1'b0;
      err_overrun <= 1'b0;
    end else begin
      if (!addr_mode) addressed <= 1'b0;
      else if (fin && ninth) addressed <= (data_m == own_addr);
      if (rd && rx_valid) begin
        rx_valid    <= 1'b0;
        err_overrun <= 1'b0;
      end
      if (fin && want) begin
        if (rx_valid && !rd) begin
          err_overrun <= 1'b1;
        end else begin
          rx_data    <= {ninth, data_m};
          rx_valid   <= 1'b1;
          err_frame  <= ferr | !s2;
          err_parity <= par_bad;
        end
      end
    end
  end
endmodule

// File: rtl/mdrop_uart.sv
module mdrop_uart #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] divisor,
  input  logic [1:0]       char_len,
  input  logic             two_stop,
  input  logic [1:0]       parity_mode,
  input  logic             addr_mode,
  input  logic [7:0]       own_addr,
  input  logic             tx_wr,
  input  logic [8:0]       tx_data,
  output logic             tx_ready,
  output logic             txd,
  input  logic             rxd,
  input  logic             rx_rd,
  output logic [8:0]       rx_data,
  output logic             rx_valid,
  output logic             err_frame,
  output logic             err_parity,
  output logic             err_overrun
);
  logic tick;

  mdu_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .divisor(divisor), .tick(tick)
  );

  mdu_tx u_tx (
    .clk(clk), .rst(rst), .tick(tick), .wr(tx_wr), .wdata(tx_data),
    .char_len(char_len), .two_stop(two_stop), .parity_mode(parity_mode),
    .addr_mode(addr_mode), .ready(tx_ready), .txd(txd)
  );

  mdu_rx u_rx (
    .clk(clk), .rst(rst), .tick(tick), .rxd(rxd), .char_len(char_len),
    .two_stop(two_stop), .parity_mode(parity_mode), .addr_mode(addr_mode),
    .own_addr(own_addr), .rd(rx_rd), .rx_data(rx_data), .rx_valid(rx_valid),
    .err_frame(err_frame), .err_parity(err_parity), .err_overrun(err_overrun)
  );
endmodule

// File: rtl/mdu_checker.sv
module mdu_checker (
  input logic       clk,
  input logic       rst,
  input logic       tx_wr,
  input logic       tx_ready,
  input logic       rx_rd,
  input logic [8:0] rx_data,
  input logic       rx_valid,
  input logic       err_frame,
  input logic       err_parity,
  input logic       err_overrun,
  input logic [1:0] parity_mode,
  input logic       addr_mode,
  input logic [7:0] own_addr
);
  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (rst)
    tx_wr && tx_ready |=> !tx_ready); // R5
  AST_RX_HELD: assert property (@(posedge clk) disable iff (rst)
    rx_valid && !rx_rd |=> rx_valid && $stable(rx_data)); // R6
  AST_OVERRUN_FULL: assert property (@(posedge clk) disable iff (rst)
    $rose(err_overrun) |-> rx_valid); // R7
  AST_FRAME_WITH_CHAR: assert property (@(posedge clk) disable iff (rst)
    $rose(err_frame) |-> rx_valid); // R4
  AST_PARITY_ENABLED: assert property (@(posedge clk) disable iff (rst)
    $rose(err_parity) |-> ($past(parity_mode) != 2'd0) && !$past(addr_mode)); // R3
  AST_NINTH_IN_ADDR: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_valid) && rx_data[8] |-> $past(addr_mode)); // R9
  AST_ADDR_MATCH: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_valid) && rx_data[8] |-> rx_data[7:0] == $past(own_addr)); // R10
endmodule

bind mdrop_uart mdu_checker u_chk (.*);

// File: tb/mdrop_uart_bench.sv
module mdrop_uart_bench;
  typedef struct packed {
    logic [1:0] dsel;
    logic [1:0] pm;
    logic       two;
    logic       adr;
    logic [8:0] d;
    logic       bad_p;
    logic       bad_s;
    logic       ev;
    logic [8:0] ed;
    logic       efe;
    logic       epe;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{2'd3, 2'd0, 1'b0, 1'b0, 9'h0A5, 1'b0, 1'b0, 1'b1, 9'h0A5, 1'b0, 1'b0},
    '{2'd0, 2'd1, 1'b0, 1'b0, 9'h0F3, 1'b0, 1'b0, 1'b1, 9'h013, 1'b0, 1'b0},
    '{2'd1, 2'd2, 1'b1, 1'b0, 9'h02D, 1'b0, 1'b0, 1'b1, 9'h02D, 1'b0, 1'b0},
    '{2'd2, 2'd1, 1'b1, 1'b0, 9'h07F, 1'b0, 1'b0, 1'b1, 9'h07F, 1'b0, 1'b0},
    '{2'd3, 2'd2, 1'b0, 1'b0, 9'h0C3, 1'b1, 1'b0, 1'b1, 9'h0C3, 1'b0, 1'b1},
    '{2'd3, 2'd0, 1'b1, 1'b0, 9'h03C, 1'b0, 1'b1, 1'b1, 9'h03C, 1'b1, 1'b0},
    '{2'd2, 2'd0, 1'b0, 1'b0, 9'h055, 1'b0, 1'b1, 1'b1, 9'h055, 1'b1, 1'b0},
    '{2'd3, 2'd0, 1'b0, 1'b1, 9'h055, 1'b0, 1'b0, 1'b0, 9'h000, 1'b0, 1'b0},
    '{2'd3, 2'd0, 1'b0, 1'b1, 9'h1A3, 1'b0, 1'b0, 1'b1, 9'h1A3, 1'b0, 1'b0},
    '{2'd3, 2'd0, 1'b0, 1'b1, 9'h042, 1'b0, 1'b0, 1'b1, 9'h042, 1'b0, 1'b0},
    '{2'd3, 2'd0, 1'b0, 1'b1, 9'h110, 1'b0, 1'b0, 1'b0, 9'h000, 1'b0, 1'b0},
    '{2'd3, 2'd0, 1'b0, 1'b1, 9'h077, 1'b0, 1'b0, 1'b0, 9'h000, 1'b0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] divisor = 16'd3;
  logic [1:0]  char_len = 2'd3;
  logic        two_stop = 1'b0;
  logic [1:0]  parity_mode = 2'd0;
  logic        addr_mode = 1'b0;
  logic [7:0]  own_addr = 8'hA3;
  logic        tx_wr = 1'b0;
  logic [8:0]  tx_data = '0;
  logic        tx_ready, txd;
  logic        rxd = 1'b1;
  logic        rx_rd = 1'b0;
  logic [8:0]  rx_data;
  logic        rx_valid, err_frame, err_parity, err_overrun;

  int n_chk = 0;
  int n_bad = 0;
  int bit_cyc = 64;

  always #4 clk = ~clk;

  mdrop_uart u_mdrop_uart (
    .clk(clk), .rst(rst), .divisor(divisor), .char_len(char_len),
    .two_stop(two_stop), .parity_mode(parity_mode), .addr_mode(addr_mode),
    .own_addr(own_addr), .tx_wr(tx_wr), .tx_data(tx_data), .tx_ready(tx_ready),
    .txd(txd), .rxd(rxd), .rx_rd(rx_rd), .rx_data(rx_data), .rx_valid(rx_valid),
    .err_frame(err_frame), .err_parity(err_parity), .err_overrun(err_overrun)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // Reference frame: start, LSB-first data, optional slot bit, stop bits.
  function automatic logic [11:0] mk(input logic [1:0] dsel, input logic [1:0] pm,
                                     input logic two, input logic adr,
                                     input logic [8:0] d, output int len);
    logic [11:0] f;
    int n, p;
    bit pb;
    f = '1;
    f[0] = 1'b0;
    n = adr ? 8 : 5 + int'(dsel);
    pb = (pm == 2'd2);
    for (int i = 0; i < n; i++) begin
      f[1+i] = d[i];
      pb = pb ^ d[i];
    end
    p = n + 1;
    if (adr) begin f[p] = d[8]; p++; end
    else if (pm != 2'd0) begin f[p] = pb; p++; end
    len = p + (two ? 2 : 1);
    return f;
  endfunction

  task automatic send_line(input logic [11:0] f, input int len);
    for (int i = 0; i < len; i++) begin
      rxd = f[i];
      repeat (bit_cyc) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (bit_cyc * 2) @(negedge clk);
  endtask

  task automatic tx_write(input logic [8:0] d);
    @(negedge clk);
    tx_data = d;
    tx_wr = 1'b1;
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  task automatic tx_decode(input logic [11:0] exp, input int len, input string req);
    logic [11:0] got;
    int to;
    got = '1;
    to = 0;
    while (txd !== 1'b0 && to < bit_cyc * 4) begin
      @(negedge clk);
      to++;
    end
    repeat (bit_cyc / 2) @(negedge clk);
    for (int i = 0; i < len; i++) begin
      got[i] = txd;
      if (i < len - 1) repeat (bit_cyc) @(negedge clk);
    end
    chk(got == exp, req, 32'(got), 32'(exp));
  endtask

  task automatic do_read();
    @(negedge clk);
    rx_rd = 1'b1;
    @(negedge clk);
    rx_rd = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog got=%h exp=%h", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [11:0] f;
    int len;
    repeat (10) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle state after reset
    chk(txd === 1'b1 && tx_ready === 1'b1, "R1 tx idle", {txd, tx_ready}, 2'b11);
    chk({rx_valid, err_frame, err_parity, err_overrun} === 4'b0, "R1 rx idle",
        {rx_valid, err_frame, err_parity, err_overrun}, 0);

    // Table: R2 R3 R4 R6 R9 R10 on receive, then the same format on transmit
    for (int v = 0; v < NV; v++) begin
      char_len = VEC[v].dsel;
      parity_mode = VEC[v].pm;
      two_stop = VEC[v].two;
      addr_mode = VEC[v].adr;
      f = mk(VEC[v].dsel, VEC[v].pm, VEC[v].two, VEC[v].adr, VEC[v].d, len);
      if (VEC[v].bad_p) f[len - (VEC[v].two ? 3 : 2)] = ~f[len - (VEC[v].two ? 3 : 2)];
      if (VEC[v].bad_s) f[len-1] = 1'b0;
      send_line(f, len);
      chk(rx_valid === VEC[v].ev, "R10 delivery", 32'(rx_valid), 32'(VEC[v].ev));
      if (VEC[v].ev) begin
        chk(rx_data === VEC[v].ed, "R2 rx data", 32'(rx_data), 32'(VEC[v].ed));
        chk(err_parity === VEC[v].epe, "R3 parity flag", 32'(err_parity), 32'(VEC[v].epe));
        chk(err_frame === VEC[v].efe, "R4 frame flag", 32'(err_frame), 32'(VEC[v].efe));
        do_read();
        chk(rx_valid === 1'b0, "R6 read clears", 32'(rx_valid), 0);
      end
      if (!VEC[v].bad_p && !VEC[v].bad_s) begin
        f = mk(VEC[v].dsel, VEC[v].pm, VEC[v].two, VEC[v].adr, VEC[v].d, len);
        tx_write(VEC[v].d);
        tx_decode(f, len, VEC[v].adr ? "R9 tx ninth bit" : "R2 tx frame");
        repeat (bit_cyc) @(negedge clk);
      end
    end

    addr_mode = 1'b0; char_len = 2'd3; parity_mode = 2'd0; two_stop = 1'b0;

    // R5: double buffering on transmit
    tx_write(9'h011);
    @(negedge clk);
    chk(tx_ready === 1'b1, "R5 holding drained", 32'(tx_ready), 1);
    tx_write(9'h022);
    chk(tx_ready === 1'b0, "R5 holding full", 32'(tx_ready), 0);
    tx_write(9'h033);
    f = mk(2'd3, 2'd0, 1'b0, 1'b0, 9'h011, len);
    tx_decode(f, len, "R5 first frame");
    f = mk(2'd3, 2'd0, 1'b0, 1'b0, 9'h022, len);
    tx_decode(f, len, "R5 second frame");
    begin
      bit low_seen = 1'b0;
      for (int c = 0; c < bit_cyc * 3; c++) begin
        @(negedge clk);
        if (txd !== 1'b1) low_seen = 1'b1;
      end
      chk(!low_seen, "R5 third write ignored", 32'(low_seen), 0);
    end

    // R7: overrun keeps the first character
    f = mk(2'd3, 2'd0, 1'b0, 1'b0, 9'h061, len);
    send_line(f, len);
    f = mk(2'd3, 2'd0, 1'b0, 1'b0, 9'h062, len);
    send_line(f, len);
    chk(err_overrun === 1'b1, "R7 overrun set", 32'(err_overrun), 1);
    chk(rx_data === 9'h061, "R7 first kept", 32'(rx_data), 32'h61);
    do_read();
    chk(err_overrun === 1'b0 && rx_valid === 1'b0, "R7 read clears",
        {err_overrun, rx_valid}, 0);

    // R8: short low pulse is rejected
    rxd = 1'b0;
    repeat (bit_cyc / 4) @(negedge clk);
    rxd = 1'b1;
    repeat (bit_cyc * 3) @(negedge clk);
    chk(rx_valid === 1'b0, "R8 glitch ignored", 32'(rx_valid), 0);

    // R11: faster divisor on both paths
    divisor = 16'd1;
    bit_cyc = 32;
    repeat (8) @(negedge clk);
    f = mk(2'd3, 2'd1, 1'b0, 1'b0, 9'h0B6, len);
    parity_mode = 2'd1;
    send_line(f, len);
    chk(rx_valid === 1'b1 && rx_data === 9'h0B6, "R11 rx at divisor 1", 32'(rx_data), 32'hB6);
    do_read();
    tx_write(9'h0B6);
    tx_decode(f, len, "R11 tx at divisor 1");
    parity_mode = 2'd0;

    // R12: simultaneous transmit and receive
    repeat (bit_cyc) @(negedge clk);
    fork
      begin
        logic [11:0] ft;
        int lt;
        ft = mk(2'd3, 2'd0, 1'b0, 1'b0, 9'h05A, lt);
        tx_write(9'h05A);
        tx_decode(ft, lt, "R12 tx during rx");
      end
      begin
        logic [11:0] fr;
        int lr;
        fr = mk(2'd3, 2'd0, 1'b0, 1'b0, 9'h0C5, lr);
        send_line(fr, lr);
      end
    join
    chk(rx_valid === 1'b1 && rx_data === 9'h0C5, "R12 rx during tx", 32'(rx_data), 32'hC5);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule